// File: doc/BRIEF.md
# Reload Down-Counter Timer

A down-counter timer, sixteen bits wide by default, that software programs through three word-wide registers: a control word, a reload value and a read-only view of the live count. Starting the timer takes two steps. An arm bit only puts the counter into standby. A trigger then loads the reload value and starts counting. The trigger is either a write of 1 to a start bit or a rising edge on an external trigger input. The counter moves only on cycles where the tick input is high, so an external prescaler sets the counting rate.

On underflow the timer either reloads and keeps running (auto-reload) or parks at all-ones and stops (single-shot). Each underflow sets a sticky flag. The flag drives an interrupt request when its enable bit is set. Software clears the flag with a write, and an acknowledge from the service controller also clears it. The timer output shares a pin with a general-purpose value through a mux, and its polarity can be selected. In auto-reload mode the output is a level that toggles on each underflow. In single-shot mode it is a pulse that lasts while counting is in progress.

Register map (addr input): 0 = control, 1 = reload, 2 = counter (read-only), 3 reads zero. Control bits: bit0 arm, bit1 start (write-only), bit2 auto-reload, bit3 interrupt enable, bit4 underflow flag, bit5 invert, bit6 pin select.

Top module: `rld_timer`

## Requirements
- R1: After reset, every register reads zero, the timer is idle, `irq` is 0 and `pin_out` follows `gpio_out`.
- R2: Setting arm (control bit0) alone does not start counting. A trigger loads the reload register into the counter and starts counting on the next clock edge, but only while arm is 1; a trigger while disarmed is ignored. A trigger is a control write with bit1 set (the arm value written in that same write applies) or a rising edge on `ext_trig`, sampled against its value in the previous cycle.
- R3: While running, the counter decrements by one on each cycle with `tick` high and holds its value on all other cycles.
- R4: An underflow is a tick while running at 0x0000. With auto-reload (bit2) set, the counter takes the reload value and keeps running. With it clear, the counter becomes 0xFFFF and stops.
- R5: The flag (bit4) is set by every underflow. A control write with bit4 = 0 clears it, and a write with bit4 = 1 leaves it unchanged. `svc_ack` clears it. If an underflow happens in the same cycle as a clear, the set wins.
- R6: `irq` is 1 exactly when interrupt enable (bit3) and the flag are both 1.
- R7: With pin select (bit6) clear, `pin_out` equals `gpio_out`. With it set, `pin_out` is the timer wave XOR invert (bit5).
- R8: In auto-reload mode the timer wave is a level that toggles on each underflow. In single-shot mode it is 1 exactly while counting is running.
- R9: The start bit always reads 0. Clearing arm stops counting on the next edge and freezes the count.
- R10: If a trigger arrives in the same cycle as an underflow, the trigger's reload takes effect, no underflow is recorded and the wave does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| tick | input | 1 | Count enable from the prescaler |
| ext_trig | input | 1 | External trigger; a rising edge starts the timer |
| svc_ack | input | 1 | Service-controller acknowledge; clears the flag |
| gpio_out | input | 1 | General-purpose value driven when the timer does not own the pin |
| pin_out | output | 1 | Muxed pin value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a trigger that lands in exactly the cycle where a running counter at zero takes a tick. To get there, a directed sequence loads a small reload value, starts the timer, ticks every cycle and raises `ext_trig` on the counted cycle of the underflow. The random phase keeps reload values in the range 0 to 7 and triggers frequently, so underflows collide with triggers, with flag clears and with disarm writes many times over. A bench model recomputes every register and output each cycle.

// File: rtl/rt_pkg.sv
// Shared types and control-bit positions for the reload timer.
// Assumes the bus data width is at least 7 bits so all control bits fit.
package rt_pkg;

    localparam int B_ARM   = 0;
    localparam int B_START = 1;
    localparam int B_AUTO  = 2;
    localparam int B_IE    = 3;
    localparam int B_FLAG  = 4;
    localparam int B_INV   = 5;
    localparam int B_PSEL  = 6;

    localparam logic [1:0] A_CTRL   = 2'd0;
    localparam logic [1:0] A_RELOAD = 2'd1;
    localparam logic [1:0] A_COUNT  = 2'd2;

    typedef struct packed {
        logic pin_sel;
        logic invert;
        logic flag;
        logic irq_en;
        logic auto_rl;
        logic arm;
    } ctrl_t;

endpackage

// File: rtl/rt_regs.sv
// Control and reload registers plus trigger generation.
// The start bit is not stored. An external rising edge is found by comparing
// the input against its value in the previous cycle. The caller guarantees
// that the input is already synchronous to clk.
module rt_regs
    import rt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             ext_trig,
    input  logic             svc_ack,
    input  logic             uf,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] reload,
    output logic             arm_eff,
    output logic             trig
);

    logic wr_ctrl;
    logic wr_rel;
    logic ext_d;
    logic ext_rise;
    logic sw_start;

    // Decode the write strobes and form the trigger.
    always_comb begin
        wr_ctrl  = wr_en && (addr == A_CTRL);
        wr_rel   = wr_en && (addr == A_RELOAD);
        ext_rise = ext_trig && !ext_d;
        sw_start = wr_ctrl && wdata[B_START];
        arm_eff  = wr_ctrl ? wdata[B_ARM] : ctrl.arm;
        trig     = arm_eff && (sw_start || ext_rise);
    end

    // Hold the previous external trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_d <= 1'b0;
        else        ext_d <= ext_trig;
    end

    // Control bits other than the flag load directly on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.arm     <= 1'b0;
            ctrl.auto_rl <= 1'b0;
            ctrl.irq_en  <= 1'b0;
            ctrl.invert  <= 1'b0;
            ctrl.pin_sel <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl.arm     <= wdata[B_ARM];
            ctrl.auto_rl <= wdata[B_AUTO];
            ctrl.irq_en  <= wdata[B_IE];
            ctrl.invert  <= wdata[B_INV];
            ctrl.pin_sel <= wdata[B_PSEL];
        end
    end

    // Sticky underflow flag: a set beats a clear by write-0 or by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                                ctrl.flag <= 1'b0;
        else if (uf)                               ctrl.flag <= 1'b1;
        else if (svc_ack || (wr_ctrl && !wdata[B_FLAG])) ctrl.flag <= 1'b0;
    end

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)      reload <= '0;
        else if (wr_rel) reload <= wdata;
    end

endmodule

// File: rtl/rt_counter.sv
// Down-counter with standby, trigger load, underflow and wave toggle.
// Assumes trig is already qualified by arm_eff. A trigger in the cycle of an
// underflow wins and suppresses the underflow.
module rt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_eff,
    input  logic             trig,
    input  logic             tick,
    input  logic             auto_rl,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             toggle,
    output logic             uf
);

    logic at_zero;

    // Detect an underflow this cycle.
    always_comb begin
        at_zero = (count == '0);
        uf      = arm_eff && !trig && running && tick && at_zero;
    end

    // Count state: disarm stops, a trigger loads, a tick decrements or underflows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            running <= 1'b0;
        end else if (!arm_eff) begin
            running <= 1'b0;
        end else if (trig) begin
            count   <= reload;
            running <= 1'b1;
        end else if (running && tick) begin
            if (at_zero) begin
                if (auto_rl) begin
                    count <= reload;
                end else begin
                    count   <= '1;
                    running <= 1'b0;
                end
            end else begin
                count <= count - 1'b1;
            end
        end
    end

    // Wave level for auto-reload mode: flips on every underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)               toggle <= 1'b0;
        else if (uf && auto_rl)   toggle <= !toggle;
    end

endmodule

// File: rtl/rt_outmux.sv
// Forms the timer wave, applies polarity, muxes the pin and gates the interrupt.
// Purely combinational; all inputs are registered elsewhere or come from ports.
module rt_outmux (
    input  logic auto_rl,
    input  logic toggle,
    input  logic running,
    input  logic invert,
    input  logic pin_sel,
    input  logic gpio_out,
    input  logic irq_en,
    input  logic flag,
    output logic pin_out,
    output logic irq
);

    logic wave;

    // Select the wave by mode, then drive the pin and the request.
    always_comb begin
        wave    = auto_rl ? toggle : running;
        pin_out = pin_sel ? (wave ^ invert) : gpio_out;
        irq     = irq_en && flag;
    end

endmodule

// File: rtl/rld_timer.sv
// Reload down-counter timer top: registers, counter, output mux and read mux.
// Assumes tick and ext_trig are synchronous to clk.
module rld_timer
    import rt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    input  logic             tick,
    input  logic             ext_trig,
    input  logic             svc_ack,
    input  logic             gpio_out,
    output logic             pin_out,
    output logic             irq
);

    localparam int CTRL_BITS = B_PSEL + 1;

    ctrl_t            ctrl_w;
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] count_w;
    logic             arm_eff_w;
    logic             trig_w;
    logic             run_w;
    logic             tgl_w;
    logic             uf_w;
    logic [CTRL_BITS-1:0] ctrl_rd;

    rt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .ext_trig (ext_trig),
        .svc_ack  (svc_ack),
        .uf       (uf_w),
        .ctrl     (ctrl_w),
        .reload   (reload_w),
        .arm_eff  (arm_eff_w),
        .trig     (trig_w)
    );

    rt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_eff (arm_eff_w),
        .trig    (trig_w),
        .tick    (tick),
        .auto_rl (ctrl_w.auto_rl),
        .reload  (reload_w),
        .count   (count_w),
        .running (run_w),
        .toggle  (tgl_w),
        .uf      (uf_w)
    );

    rt_outmux u_mux (
        .auto_rl  (ctrl_w.auto_rl),
        .toggle   (tgl_w),
        .running  (run_w),
        .invert   (ctrl_w.invert),
        .pin_sel  (ctrl_w.pin_sel),
        .gpio_out (gpio_out),
        .irq_en   (ctrl_w.irq_en),
        .flag     (ctrl_w.flag),
        .pin_out  (pin_out),
        .irq      (irq)
    );

    // Pack the control word for reading; the start bit always reads 0.
    always_comb begin
        ctrl_rd          = '0;
        ctrl_rd[B_ARM]   = ctrl_w.arm;
        ctrl_rd[B_AUTO]  = ctrl_w.auto_rl;
        ctrl_rd[B_IE]    = ctrl_w.irq_en;
        ctrl_rd[B_FLAG]  = ctrl_w.flag;
        ctrl_rd[B_INV]   = ctrl_w.invert;
        ctrl_rd[B_PSEL]  = ctrl_w.pin_sel;
    end

    // Read mux.
    always_comb begin
        unique case (addr)
            A_CTRL:   rdata = {{(CNT_W-CTRL_BITS){1'b0}}, ctrl_rd};
            A_RELOAD: rdata = reload_w;
            A_COUNT:  rdata = count_w;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/rld_timer_chk.sv
// Assertion checker for rld_timer, attached with bind below.
// Observes internal nets between the register block and the counter.
module rld_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       addr,
    input logic [CNT_W-1:0] rdata,
    input logic             tick,
    input logic             arm_eff,
    input logic             trig,
    input logic             running,
    input logic             uf,
    input logic             auto_rl,
    input logic             flag,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] count
);

    // R2
    trig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (running && count == $past(reload)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !(running && tick)) |=> $stable(count));

    // R4
    auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && auto_rl) |=> (running && count == $past(reload)));

    // R4
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && !auto_rl) |=> (!running && count == {CNT_W{1'b1}}));

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> flag);

    // R9
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_eff |=> !running);

    // R9
    start_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd0) |-> !rdata[1]);

endmodule

bind rld_timer rld_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rdata   (rdata),
    .tick    (tick),
    .arm_eff (arm_eff_w),
    .trig    (trig_w),
    .running (run_w),
    .uf      (uf_w),
    .auto_rl (ctrl_w.auto_rl),
    .flag    (ctrl_w.flag),
    .reload  (reload_w),
    .count   (count_w)
);

// File: tb/rld_timer_tb.sv
// Self-checking bench: a cycle model computed from the requirements, directed
// corner cases, then constrained random stimulus with a fixed seed.
module rld_timer_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         tick = 1'b0;
    logic         ext_trig = 1'b0;
    logic         svc_ack = 1'b0;
    logic         gpio_out = 1'b0;
    logic         pin_out;
    logic         irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // model state
    logic m_arm, m_auto, m_ie, m_flag, m_inv, m_ps;
    logic m_run, m_tgl, m_extd;
    logic [W-1:0] m_rel, m_cnt;

    always #4 clk = ~clk;

    rld_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick(tick), .ext_trig(ext_trig), .svc_ack(svc_ack),
        .gpio_out(gpio_out), .pin_out(pin_out), .irq(irq)
    );

    function automatic logic [W-1:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {9'd0, m_ps, m_inv, m_flag, m_ie, m_auto, 1'b0, m_arm};
            2'd1: return m_rel;
            2'd2: return m_cnt;
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_pin();
        logic wv;
        wv = m_auto ? m_tgl : m_run;
        return m_ps ? (wv ^ m_inv) : gpio_out;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        {m_arm, m_auto, m_ie, m_flag, m_inv, m_ps} = '0;
        {m_run, m_tgl, m_extd} = '0;
        m_rel = '0;
        m_cnt = '0;
    endtask

    // Compare every output against the model for the current inputs.
    task automatic compare();
        case (addr)
            2'd0: chk("R5/R9 control readback", rdata, exp_rd(addr));
            2'd1: chk("R2 reload readback", rdata, exp_rd(addr));
            2'd2: chk("R3/R4 count readback", rdata, exp_rd(addr));
            default: chk("R1 unused address", rdata, '0);
        endcase
        chk("R7/R8 pin", {15'd0, pin_out}, {15'd0, exp_pin()});
        chk("R6 irq", {15'd0, irq}, {15'd0, m_ie && m_flag});
    endtask

    // Advance one clock: compute model next state from present inputs, then compare.
    task automatic step();
        logic wc, wr, arm_e, rise, tr, uf;
        logic [W-1:0] n_cnt;
        logic n_run;
        wc    = wr_en && addr == 2'd0;
        wr    = wr_en && addr == 2'd1;
        arm_e = wc ? wdata[0] : m_arm;
        rise  = ext_trig && !m_extd;
        tr    = arm_e && ((wc && wdata[1]) || rise);
        uf    = arm_e && !tr && m_run && tick && m_cnt == '0;
        n_cnt = m_cnt;
        n_run = m_run;
        if (!arm_e) n_run = 1'b0;
        else if (tr) begin n_cnt = m_rel; n_run = 1'b1; end
        else if (m_run && tick) begin
            if (m_cnt == '0) begin
                if (m_auto) n_cnt = m_rel;
                else begin n_cnt = '1; n_run = 1'b0; end
            end else n_cnt = m_cnt - 1'b1;
        end
        @(posedge clk);
        if (!rst_n) model_reset();
        else begin
            if (uf && m_auto) m_tgl = !m_tgl;
            m_cnt = n_cnt;
            m_run = n_run;
            if (uf) m_flag = 1'b1;
            else if (svc_ack || (wc && !wdata[4])) m_flag = 1'b0;
            if (wc) begin
                m_arm = wdata[0]; m_auto = wdata[2]; m_ie = wdata[3];
                m_inv = wdata[5]; m_ps = wdata[6];
            end
            if (wr) m_rel = wdata;
            m_extd = ext_trig;
        end
        #1;
        compare();
    endtask

    task automatic idle();
        wr_en = 1'b0; svc_ack = 1'b0; ext_trig = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic peek(input string tag, input logic [1:0] a);
        addr = a;
        #1;
        chk(tag, rdata, exp_rd(a));
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        model_reset();
        step(); step();
        rst_n = 1'b1;

        // R1: reset state on every readable location and on the outputs
        gpio_out = 1'b1;
        peek("R1 control after reset", 2'd0);
        chk("R1 control is zero", rdata, '0);
        peek("R1 reload after reset", 2'd1);
        peek("R1 count after reset", 2'd2);
        chk("R1 pin follows gpio", {15'd0, pin_out}, 16'd1);
        chk("R1 irq low", {15'd0, irq}, '0);

        // R2: a trigger while disarmed is ignored; arming alone does not count
        wr(2'd1, 16'd3);
        ext_trig = 1'b1; step(); ext_trig = 1'b0; step();
        peek("R2 disarmed trigger ignored", 2'd2);
        chk("R2 count still zero", rdata, '0);
        wr(2'd0, 16'h004D);          // arm, auto, irq enable, pin select
        tick = 1'b1;
        repeat (3) step();
        peek("R2 armed without trigger holds", 2'd2);

        // R2/R3/R4/R8: software start, count down, reload and toggle
        wr(2'd0, 16'h004F);
        peek("R2 start loads reload", 2'd2);
        chk("R2 start loads 3", rdata, 16'd3);
        repeat (4) step();
        peek("R4 auto reload after underflow", 2'd2);
        chk("R8 wave toggled", {15'd0, pin_out}, 16'd1);
        chk("R6 irq after underflow", {15'd0, irq}, 16'd1);

        // R5: write 1 keeps flag, acknowledge clears it, start bit reads 0
        wr(2'd0, 16'h005D);
        peek("R5 write one keeps flag / R9 start reads 0", 2'd0);
        svc_ack = 1'b1; step(); svc_ack = 1'b0;
        peek("R5 acknowledge clears flag", 2'd0);

        // R10: external trigger on the exact underflow cycle
        wr(2'd1, 16'd2);
        wr(2'd0, 16'h004F);          // count = 2
        step(); step();              // 1, then 0
        ext_trig = 1'b1; step(); ext_trig = 1'b0;
        peek("R10 trigger wins over underflow", 2'd2);
        chk("R10 count reloaded", rdata, 16'd2);
        peek("R10 no flag recorded", 2'd0);
        chk("R10 flag clear", rdata & 16'h0010, '0);

        // R4/R8: single-shot with inverted pulse
        wr(2'd0, 16'h0063);          // arm, start, invert, pin select
        chk("R8 pulse active (inverted)", {15'd0, pin_out}, '0);
        repeat (4) step();
        peek("R4 single shot parks at all-ones", 2'd2);
        chk("R4 value FFFF", rdata, 16'hFFFF);
        chk("R8 pulse ended", {15'd0, pin_out}, 16'd1);

        // R9: disarm during counting freezes the count
        wr(2'd1, 16'd9);
        wr(2'd0, 16'h0007);
        step();
        wr(2'd0, 16'h0004);
        repeat (3) step();
        peek("R9 disarm freezes count", 2'd2);

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            wr_en    = ($urandom % 12) == 0;
            addr     = 2'($urandom % 4);
            wdata    = W'($urandom);
            if (addr == 2'd0) wdata[0] = ($urandom % 8) != 0;
            if (addr == 2'd1) wdata = W'($urandom % 8);
            tick     = ($urandom % 3) != 0;
            if (($urandom % 10) == 0) ext_trig = !ext_trig;
            svc_ack  = ($urandom % 24) == 0;
            gpio_out = 1'($urandom);
            step();
        end
        idle();
        step();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule